// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer operand into an IEEE-754 binary64 value. A mode input says whether the operand is read as a two's-complement signed number or as an unsigned number. The exact value is normalised with a leading-zero count and then rounded under a 2-bit rounding-mode field.

A precision option rounds the value to a 24-bit binary32 significand instead. That result is then returned exactly as a binary64 word. Next to the result the block reports a 5-bit class code and two rounding flags. The first flag says the magnitude was rounded up. The second says the result is inexact.

Whenever the result is inexact, the block raises an inexact-exception request and a summary-exception request. An operand presented with `in_valid` produces its outputs, with `out_valid`, on the next clock edge. Operands may arrive back to back.

Top module: `ifp_convert`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is 0, `out_result` is all zeros and both exception requests are 0.
- R2: An operand accepted with `in_valid` = 1 at a clock edge has its outputs, with `out_valid` = 1, after that edge. A cycle with `in_valid` = 0 gives `out_valid` = 0 one cycle later.
- R3: With `in_signed` = 1 the operand is a two's-complement value; a set bit 63 gives a negative result (result bit 63 set) of the negated magnitude. With `in_signed` = 0 the operand is unsigned and the result is never negative.
- R4: `in_rmode` selects the rounding to a 53-bit significand. 00 is nearest with ties to the even significand, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity. A carry out of the significand raises the exponent by one.
- R5: With `in_single` = 1 the value is rounded to a 24-bit significand under the same mode encoding. It is returned as binary64 with the low 29 fraction bits zero.
- R6: `out_rounded_up` is 1 exactly when the chosen result has a larger magnitude than the truncated significand.
- R7: `out_inexact` is 1 exactly when the result differs from the integer value. Guard, round and sticky are taken from the bits below the active significand.
- R8: `exc_inexact_req` and `exc_summary_req` are both 1 exactly in an output cycle with `out_inexact` = 1, and 0 otherwise.
- R9: `out_class` is 00100 for a positive nonzero result and 01000 for a negative one.
- R10: A zero operand, signed or not, in any mode, gives an all-zero result, class 00010 and both rounding flags 0.
- R11: An operand whose magnitude fits the active significand converts exactly, with both rounding flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | Integer operand |
| in_signed | input | 1 | 1: two's complement, 0: unsigned |
| in_rmode | input | 2 | Rounding mode (00 nearest-even, 01 zero, 10 +inf, 11 -inf) |
| in_single | input | 1 | 1: round to 24-bit significand, widened to binary64 |
| out_valid | output | 1 | Outputs below belong to an accepted operand |
| out_result | output | 64 | binary64 result |
| out_class | output | 5 | Result class code |
| out_rounded_up | output | 1 | Magnitude was increased by rounding |
| out_inexact | output | 1 | Result differs from the exact value |
| exc_inexact_req | output | 1 | Inexact exception request |
| exc_summary_req | output | 1 | Summary exception request |

## Verification
On every cycle the assertions check several properties. They check the one-cycle valid timing. They check that a rounded-up result is always marked inexact, and that the exception requests stay low without a result. They check that single-precision results carry zero low fraction bits, that negative results carry the negative class, that unsigned operands never give negative results, and that zero results are flag-free.

Only the bench's scenarios can show that the rounded value itself is correct. That covers ties to even, the directed modes on both signs, the carry into the next binade at the top of the unsigned range, and the most negative signed value. The bench compares each one against an independent integer-arithmetic model.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
    localparam int unsigned OP_W      = 64;
    localparam int unsigned DP_SIG_W  = 53;
    localparam int unsigned SP_SIG_W  = 24;
    localparam int unsigned DP_EXP_W  = 11;
    localparam int unsigned DP_FRAC_W = DP_SIG_W - 1;
    localparam int unsigned SP_FRAC_W = SP_SIG_W - 1;
    localparam int unsigned DP_BIAS   = 1023;
    localparam int unsigned CLS_W     = 5;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_POS_ZERO = 5'b00010,
        CLS_POS_NORM = 5'b00100,
        CLS_NEG_NORM = 5'b01000,
        CLS_NEG_ZERO = 5'b10010
    } fclass_e;

    typedef struct packed {
        logic                 valid;
        logic [OP_W-1:0]      result;
        logic [CLS_W-1:0]     cls;
        logic                 rounded_up;
        logic                 inexact;
    } conv_state_s;
endpackage

// File: rtl/ifp_lzc.sv
module ifp_lzc #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    logic found;

    always_comb begin
        count = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                count = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ifp_round.sv
module ifp_round
    import ifp_pkg::*;
#(
    parameter int unsigned W     = 64,
    parameter int unsigned SIG_W = 53
) (
    input  logic [W-2:0]       norm_tail,
    input  logic               sign,
    input  rmode_e             rmode,
    output logic [SIG_W-2:0]   frac,
    output logic               carry,
    output logic               inc,
    output logic               inexact
);
    localparam int unsigned TAIL_W = W - SIG_W;

    logic [SIG_W-2:0] trunc_frac;
    logic             guard_b;
    logic             round_b;
    logic             sticky_b;

    assign trunc_frac = norm_tail[W-2 -: SIG_W-1];
    assign guard_b    = norm_tail[TAIL_W-1];
    assign round_b    = norm_tail[TAIL_W-2];
    assign sticky_b   = |norm_tail[TAIL_W-3:0];
    assign inexact    = guard_b | round_b | sticky_b;

    always_comb begin
        case (rmode)
            RM_NEAR_EVEN: inc = guard_b & (round_b | sticky_b | trunc_frac[0]);
            RM_TO_ZERO:   inc = 1'b0;
            RM_TO_POS:    inc = ~sign & inexact;
            RM_TO_NEG:    inc = sign & inexact;
            default:      inc = 1'b0;
        endcase
        {carry, frac} = {1'b0, trunc_frac} + SIG_W'(inc);
    end

    // R6
    always_comb begin
        inc_needs_inexact_chk: assert (!inc || inexact);
    end
endmodule

// File: rtl/ifp_pack.sv
module ifp_pack
    import ifp_pkg::*;
#(
    parameter int unsigned LZ_W = $clog2(OP_W)
) (
    input  logic                 sign,
    input  logic                 nonzero,
    input  logic [LZ_W-1:0]      lz,
    input  logic                 single,
    input  logic [DP_FRAC_W-1:0] dp_frac,
    input  logic                 dp_carry,
    input  logic                 dp_inc,
    input  logic                 dp_inexact,
    input  logic [SP_FRAC_W-1:0] sp_frac,
    input  logic                 sp_carry,
    input  logic                 sp_inc,
    input  logic                 sp_inexact,
    output logic [OP_W-1:0]      result,
    output logic [CLS_W-1:0]     cls,
    output logic                 rounded_up,
    output logic                 inexact
);
    localparam int unsigned EXP_TOP = DP_BIAS + OP_W - 1;
    localparam int unsigned PAD_W   = DP_FRAC_W - SP_FRAC_W;

    logic [DP_EXP_W-1:0]  exp_b;
    logic [DP_FRAC_W-1:0] frac_sel;
    logic                 carry_sel;

    always_comb begin
        carry_sel = single ? sp_carry : dp_carry;
        frac_sel  = single ? {sp_frac, {PAD_W{1'b0}}} : dp_frac;
        exp_b     = DP_EXP_W'(EXP_TOP) - DP_EXP_W'(lz) + DP_EXP_W'(carry_sel);
        if (nonzero) begin
            result     = {sign, exp_b, frac_sel};
            cls        = sign ? CLS_NEG_NORM : CLS_POS_NORM;
            rounded_up = single ? sp_inc : dp_inc;
            inexact    = single ? sp_inexact : dp_inexact;
        end else begin
            result     = '0;
            cls        = CLS_POS_ZERO;
            rounded_up = 1'b0;
            inexact    = 1'b0;
        end
    end
endmodule

// File: rtl/ifp_convert.sv
module ifp_convert
    import ifp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     in_operand,
    input  logic                in_signed,
    input  logic [1:0]          in_rmode,
    input  logic                in_single,
    output logic                out_valid,
    output logic [OP_W-1:0]     out_result,
    output logic [CLS_W-1:0]    out_class,
    output logic                out_rounded_up,
    output logic                out_inexact,
    output logic                exc_inexact_req,
    output logic                exc_summary_req
);
    localparam int unsigned LZ_W    = $clog2(OP_W);
    localparam int unsigned SP_ZERO = DP_FRAC_W - SP_FRAC_W;

    conv_state_s state_d, state_q;

    logic                 op_neg;
    logic [OP_W-1:0]      mag;
    logic [LZ_W-1:0]      lz;
    logic [OP_W-1:0]      norm;
    rmode_e               rmode;
    logic [DP_FRAC_W-1:0] dp_frac;
    logic                 dp_carry, dp_inc, dp_inexact;
    logic [SP_FRAC_W-1:0] sp_frac;
    logic                 sp_carry, sp_inc, sp_inexact;
    logic [OP_W-1:0]      pk_result;
    logic [CLS_W-1:0]     pk_cls;
    logic                 pk_up, pk_inexact;

    assign op_neg = in_signed & in_operand[OP_W-1];
    assign mag    = op_neg ? (~in_operand + OP_W'(1)) : in_operand;
    assign rmode  = rmode_e'(in_rmode);
    assign norm   = mag << lz;

    ifp_lzc #(.W(OP_W), .CW(LZ_W)) u_lzc (
        .vec   (mag),
        .count (lz)
    );

    ifp_round #(.W(OP_W), .SIG_W(DP_SIG_W)) u_round_dp (
        .norm_tail (norm[OP_W-2:0]),
        .sign      (op_neg),
        .rmode     (rmode),
        .frac      (dp_frac),
        .carry     (dp_carry),
        .inc       (dp_inc),
        .inexact   (dp_inexact)
    );

    ifp_round #(.W(OP_W), .SIG_W(SP_SIG_W)) u_round_sp (
        .norm_tail (norm[OP_W-2:0]),
        .sign      (op_neg),
        .rmode     (rmode),
        .frac      (sp_frac),
        .carry     (sp_carry),
        .inc       (sp_inc),
        .inexact   (sp_inexact)
    );

    ifp_pack #(.LZ_W(LZ_W)) u_pack (
        .sign       (op_neg),
        .nonzero    (norm[OP_W-1]),
        .lz         (lz),
        .single     (in_single),
        .dp_frac    (dp_frac),
        .dp_carry   (dp_carry),
        .dp_inc     (dp_inc),
        .dp_inexact (dp_inexact),
        .sp_frac    (sp_frac),
        .sp_carry   (sp_carry),
        .sp_inc     (sp_inc),
        .sp_inexact (sp_inexact),
        .result     (pk_result),
        .cls        (pk_cls),
        .rounded_up (pk_up),
        .inexact    (pk_inexact)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.result     = pk_result;
            state_d.cls        = pk_cls;
            state_d.rounded_up = pk_up;
            state_d.inexact    = pk_inexact;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid       = state_q.valid;
    assign out_result      = state_q.result;
    assign out_class       = state_q.cls;
    assign out_rounded_up  = state_q.rounded_up;
    assign out_inexact     = state_q.inexact;
    assign exc_inexact_req = state_q.valid & state_q.inexact;
    assign exc_summary_req = state_q.valid & state_q.inexact;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    unsigned_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed) |=> !out_result[OP_W-1]);
    // R5
    single_widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_single) |=> (out_result[SP_ZERO-1:0] == '0));
    // R6
    up_implies_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rounded_up) |-> out_inexact);
    // R8
    exc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(exc_inexact_req || exc_summary_req));
    // R9
    neg_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[OP_W-1]) |-> (out_class == CLS_NEG_NORM));
    // R10
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == CLS_POS_ZERO) |->
        (out_result == '0 && !out_inexact && !out_rounded_up));
endmodule

// File: tb/test_ifp_convert.sv
module test_ifp_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic        in_signed = 1'b0;
    logic [1:0]  in_rmode = 2'b00;
    logic        in_single = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [4:0]  out_class;
    logic        out_rounded_up, out_inexact, exc_inexact_req, exc_summary_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        e_valid = 1'b0;
    logic [63:0] e_res = '0;
    logic [4:0]  e_cls = '0;
    logic        e_up = 1'b0, e_inx = 1'b0;
    string       e_tag = "R2";
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    ifp_convert i_ifp_convert (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_signed(in_signed), .in_rmode(in_rmode), .in_single(in_single),
        .out_valid(out_valid), .out_result(out_result), .out_class(out_class),
        .out_rounded_up(out_rounded_up), .out_inexact(out_inexact),
        .exc_inexact_req(exc_inexact_req), .exc_summary_req(exc_summary_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic model(input logic [63:0] op, input logic sgn, input logic [1:0] rm,
                         input logic sp, output logic [63:0] res, output logic [4:0] cls,
                         output logic up, output logic inx, output string tag);
        logic neg;
        logic [64:0] mag, lo, trunc, upv, half, pick, unit;
        logic [127:0] t;
        int m, p, sh, mm;
        neg = sgn && op[63];
        mag = {1'b0, neg ? (~op + 64'd1) : op};
        lo = '0; trunc = mag; upv = mag; half = '0; pick = mag; unit = 65'd1;
        t = '0; m = 0; mm = 0; sh = 0;
        p = sp ? 24 : 53;
        if (mag == 65'd0) begin
            res = '0; cls = 5'b00010; up = 1'b0; inx = 1'b0; tag = "R10";
        end else begin
            for (int i = 0; i < 65; i++) if (mag[i]) m = i;
            if (m >= p) begin
                sh = m - p + 1;
                unit = 65'd1 << sh;
                lo = mag & (unit - 65'd1);
                trunc = mag - lo;
                upv = trunc + unit;
                half = unit >> 1;
                case (rm)
                    2'b00: begin
                        if (lo > half) pick = upv;
                        else if (lo < half) pick = trunc;
                        else pick = trunc[sh] ? upv : trunc;
                    end
                    2'b01: pick = trunc;
                    2'b10: pick = (!neg && lo != 0) ? upv : trunc;
                    default: pick = (neg && lo != 0) ? upv : trunc;
                endcase
            end
            inx = (lo != 0);
            up = (pick != trunc);
            for (int i = 0; i < 65; i++) if (pick[i]) mm = i;
            t = {63'd0, pick} << (127 - mm);
            res = {neg, 11'(mm + 1023), t[126:75]};
            cls = neg ? 5'b01000 : 5'b00100;
            if (neg) tag = "R3";
            else if (!inx) tag = "R11";
            else if (sp) tag = "R5";
            else tag = "R4";
        end
    endtask

    task automatic compare_now();
        chk("R2 valid", {63'd0, out_valid}, {63'd0, e_valid});
        if (e_valid) begin
            chk({e_tag, " result"}, out_result, e_res);
            chk("R9 class", {59'd0, out_class}, {59'd0, e_cls});
            chk("R6 rounded_up", {63'd0, out_rounded_up}, {63'd0, e_up});
            chk("R7 inexact", {63'd0, out_inexact}, {63'd0, e_inx});
        end
        chk("R8 inexact_req", {63'd0, exc_inexact_req}, {63'd0, e_valid & e_inx});
        chk("R8 summary_req", {63'd0, exc_summary_req}, {63'd0, e_valid & e_inx});
    endtask

    task automatic step(input logic v, input logic [63:0] op, input logic sgn,
                        input logic [1:0] rm, input logic sp);
        logic [63:0] r; logic [4:0] c; logic u, x; string tg;
        @(negedge clk);
        compare_now();
        e_valid = v;
        if (v) begin
            model(op, sgn, rm, sp, r, c, u, x, tg);
            e_res = r; e_cls = c; e_up = u; e_inx = x; e_tag = tg;
        end
        in_valid = v; in_operand = op; in_signed = sgn; in_rmode = rm; in_single = sp;
    endtask

    task automatic all_modes(input logic [63:0] op, input logic sgn);
        for (int sp = 0; sp < 2; sp++)
            for (int rm = 0; rm < 4; rm++)
                step(1'b1, op, sgn, 2'(rm), 1'(sp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1 valid", {63'd0, out_valid}, 64'd0);
        chk("R1 result", out_result, 64'd0);
        chk("R1 req", {62'd0, exc_inexact_req, exc_summary_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", {63'd0, out_valid}, 64'd0);

        // R10 zero in every mode, both interpretations
        all_modes(64'd0, 1'b0);
        all_modes(64'd0, 1'b1);
        // R11 exact small values
        all_modes(64'd1, 1'b0);
        all_modes(64'h0000_0000_00FF_FFFF, 1'b0);
        all_modes(64'h001F_FFFF_FFFF_FFFF, 1'b1);
        // R3 signed negatives and the most negative value
        all_modes(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        all_modes(64'h8000_0000_0000_0000, 1'b1);
        all_modes(64'h8000_0000_0000_0000, 1'b0);
        // R4 ties and carry into the next binade
        all_modes(64'h0020_0000_0000_0001, 1'b0);
        all_modes(64'h0020_0000_0000_0003, 1'b0);
        all_modes(64'hFFDF_FFFF_FFFF_FFFF, 1'b1);
        all_modes(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        // R5 single-precision ties
        all_modes(64'h0000_0000_0100_0001, 1'b0);
        all_modes(64'h0000_0000_0100_0003, 1'b1);
        all_modes(64'hFFFF_FFFF_FEFF_FFFD, 1'b1);
        // R2 gaps between operands
        step(1'b0, 64'd5, 1'b0, 2'b00, 1'b0);
        step(1'b1, 64'd7, 1'b0, 2'b10, 1'b0);
        step(1'b0, 64'd9, 1'b1, 2'b11, 1'b1);
        step(1'b0, 64'd9, 1'b1, 2'b11, 1'b1);

        for (int n = 0; n < 3000; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            step(lfsr[0] | lfsr[1], lfsr >> lfsr[7:2], lfsr[8], lfsr[10:9], lfsr[11]);
        end
        step(1'b0, 64'd0, 1'b0, 2'b00, 1'b0);
        step(1'b0, 64'd0, 1'b0, 2'b00, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule